// File: doc/BRIEF.md
# Baseband Header Decoder and User Packet Recovery

This block takes a descrambled baseband frame one bit per clock, together with frame start, frame end and bit-valid strobes. The first 80 bits of every frame are a header protected by an 8-bit CRC. The block checks that CRC, publishes the decoded header fields, and then handles the data field that follows. A frame whose header fails the check is dropped in full.

Two output modes are selected by the stream format field of the header. In continuous mode the data field bits are forwarded unchanged, with strobes marking the first and last bit of the field. In packetized mode the data field is cut into user packets of a fixed bit length. The sync distance field gives the first packet boundary, and a packet left unfinished at the end of one frame continues in the next. Each packet leaves the block with start, end and valid strobes. Its leading byte is replaced by the configured sync word. The byte received in that position holds the CRC of the previous packet and is checked against it.

Top module: `bbr_stream_recover`

## Requirements
- R1: The header is received first bit first, as an 80-bit word.
  - Bits 79:78 carry the stream format, bit 77 the multi-stream flag, bit 76 the adaptive-coding flag, bit 75 the stream-sync indicator and bit 74 the null-packet-deletion flag.
  - Bits 73:72 carry the roll-off, 71:64 the stream identifier, 63:48 the user packet length in bits (UPL) and 47:32 the data field length in bits (DFL).
  - Bits 31:24 carry the sync word, 23:8 the sync distance and 7:0 the CRC.
  - The field outputs take the new values one cycle after the 80th header bit when the CRC passes, and hold their values otherwise.
- R2: The header CRC uses the polynomial 0xD5 (x^8+x^7+x^6+x^4+x^2+1) over bits 79:8, starting from zero. It is compared with bits 7:0. `hdr_crc_status` is 2'b01 for one cycle on a pass and 2'b11 for one cycle on a fail, both one cycle after the 80th header bit. Otherwise it is 2'b00.
- R3: A frame whose header CRC fails produces no valid output bit. It also discards any packet carried over from earlier frames, and the pending CRC comparison.
- R4: Only the first DFL bits after the header form the data field. Later bits of the frame produce no output.
- R5: When the stream format is 2'b01 (continuous mode), each data bit appears on `out_bit` with `out_valid` one cycle after it is received. `out_start` marks the first data bit and `out_end` the last. `pkt_err` and `pkt_invalid` stay low.
- R6: In packetized mode, a packet begins at data bit index SYNCD, counted from 0. Packets of UPL bits then follow back to back. `out_start` marks bit 0 of each packet and `out_end` marks bit UPL-1.
- R7: The first 8 output bits of every packet are the header sync word, most significant bit first, whatever was received there.
- R8: The packet CRC (same polynomial, zero start) covers packet bits 8 to UPL-1. It is compared with the 8 bits received in the sync position of the next packet. On a mismatch, `pkt_err` is high together with output bit 7 of that next packet. There is no comparison for the first packet after reset or after a dropped frame.
- R9: Data bits before SYNCD are dropped when no packet is pending. For each such bit `pkt_invalid` is high for one cycle and `out_valid` is low.
- R10: A packet unfinished at the end of a frame continues with the first data bits of the next passing frame, before SYNCD.
- R11: Cycles with `in_valid` low are ignored and produce no output.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_bit | input | 1 | Serial frame bit |
| in_valid | input | 1 | in_bit is valid |
| in_start | input | 1 | First bit of a frame |
| in_end | input | 1 | Last bit of a frame |
| out_bit | output | 1 | Recovered stream bit |
| out_valid | output | 1 | out_bit is valid |
| out_start | output | 1 | First bit of a packet or data field |
| out_end | output | 1 | Last bit of a packet or data field |
| pkt_err | output | 1 | Previous packet failed its CRC |
| pkt_invalid | output | 1 | A data bit was dropped (no pending packet) |
| hdr_crc_status | output | 2 | {fail, reported} header CRC result |
| f_stream_fmt | output | 2 | Stream format |
| f_multi_stream | output | 1 | Multi-stream flag |
| f_acm | output | 1 | Adaptive/variable coding flag |
| f_issy | output | 1 | Stream-sync indicator |
| f_npd | output | 1 | Null-packet-deletion flag |
| f_roll_off | output | 2 | Roll-off code |
| f_stream_id | output | 8 | Stream identifier (reserved for single stream) |
| f_upl | output | 16 | User packet length in bits |
| f_dfl | output | 16 | Data field length in bits |
| f_sync | output | 8 | Configured sync word |
| f_syncd | output | 16 | Sync distance in bits |

## Verification
A wrong packet counter or pending flag shifts every later start and end strobe. It shows at the ports on the first packet boundary of the frame, which is at most UPL bits away. A corrupted running or held CRC shows up as a false or missing `pkt_err` at bit 7 of the next packet. A header CRC or frame-state fault shows up in `hdr_crc_status` one cycle after the header. Such a fault also lets data out of a frame that failed its check, or blocks data from one that passed.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  parameter int LEN_W    = 16;
  parameter int HDR_BITS = 80;
  parameter int CRC_W    = 8;
  parameter int SYNC_W   = 8;
  parameter int CRC_SPAN = HDR_BITS - CRC_W;
  parameter logic [CRC_W-1:0] CRC_POLY = 8'hD5;
  parameter logic [1:0] FMT_CONT = 2'b01;

  typedef struct packed {
    logic [1:0]        fmt;
    logic              multi;
    logic              acm;
    logic              issy;
    logic              npd;
    logic [1:0]        roll;
    logic [7:0]        sid;
    logic [LEN_W-1:0]  upl;
    logic [LEN_W-1:0]  dfl;
    logic [SYNC_W-1:0] sync;
    logic [LEN_W-1:0]  syncd;
  } hdr_t;

  // one serial CRC step, MSB-first feedback
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // header word (first received bit at MSB) to fields
  function automatic hdr_t hdr_unpack(input logic [HDR_BITS-1:0] v);
    hdr_t h;
    h.fmt   = v[79:78];
    h.multi = v[77];
    h.acm   = v[76];
    h.issy  = v[75];
    h.npd   = v[74];
    h.roll  = v[73:72];
    h.sid   = v[71:64];
    h.upl   = v[63:48];
    h.dfl   = v[47:32];
    h.sync  = v[31:24];
    h.syncd = v[23:8];
    return h;
  endfunction
endpackage

// File: rtl/bbr_hdr_parse.sv
module bbr_hdr_parse
  import bbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_bit,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic             in_end,
  output hdr_t             fields,
  output logic             hdr_ok,
  output logic             hdr_fail,
  output logic             d_vld,
  output logic             d_bit,
  output logic             d_first,
  output logic             d_last,
  output logic [LEN_W-1:0] d_idx
);
  localparam int HC_W = $clog2(HDR_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_SKIP} st_t;

  st_t                 st;
  logic [HC_W-1:0]     hcnt;
  logic [HDR_BITS-2:0] sh;
  logic [CRC_W-1:0]    crc;
  logic [LEN_W-1:0]    dcnt;

  logic                hdr_ev, hdr_last, crc_ok;
  logic [HC_W-1:0]     cur_idx;
  logic [CRC_W-1:0]    crc_base;
  logic [HDR_BITS-1:0] full;

  always_comb begin
    hdr_ev   = in_valid && (in_start || st == S_HDR);
    cur_idx  = in_start ? '0 : hcnt;
    crc_base = in_start ? '0 : crc;
    hdr_last = hdr_ev && (cur_idx == HC_W'(HDR_BITS - 1));
    full     = {sh, in_bit};
    crc_ok   = (crc == full[CRC_W-1:0]);
    hdr_ok   = hdr_last && crc_ok;
    hdr_fail = hdr_last && !crc_ok;
    d_vld    = in_valid && !in_start && (st == S_DATA);
    d_bit    = in_bit;
    d_idx    = dcnt;
    d_first  = (dcnt == '0);
    d_last   = (dcnt == fields.dfl - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hcnt   <= '0;
      sh     <= '0;
      crc    <= '0;
      dcnt   <= '0;
      fields <= '0;
    end else if (in_valid) begin
      if (hdr_ev) begin
        sh   <= {sh[HDR_BITS-3:0], in_bit};
        crc  <= (int'(cur_idx) < CRC_SPAN) ? crc_step(crc_base, in_bit) : crc_base;
        hcnt <= cur_idx + 1'b1;
        st   <= S_HDR;
        if (hdr_last) begin
          dcnt <= '0;
          if (crc_ok) begin
            fields <= hdr_unpack(full);
            st     <= (hdr_unpack(full).dfl == '0) ? S_SKIP : S_DATA;
          end else begin
            st <= S_SKIP;
          end
        end
      end else if (d_vld) begin
        dcnt <= dcnt + 1'b1;
        if (d_last) st <= S_SKIP;
      end
      if (in_end) st <= S_IDLE;
    end
  end

  // data strobes never run past the data field length (R4)
  p_data_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    d_vld |-> (d_idx < fields.dfl));
endmodule

// File: rtl/bbr_pkt_frame.sv
module bbr_pkt_frame
  import bbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_vld,
  input  logic              d_bit,
  input  logic              d_first,
  input  logic              d_last,
  input  logic [LEN_W-1:0]  d_idx,
  input  logic [LEN_W-1:0]  upl,
  input  logic [LEN_W-1:0]  syncd,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              cont_mode,
  input  logic              flush,
  output logic              o_bit,
  output logic              o_vld,
  output logic              o_start,
  output logic              o_end,
  output logic              o_err,
  output logic              o_inv
);
  localparam int SEL_W = $clog2(SYNC_W);

  logic              active, have_prev;
  logic [LEN_W-1:0]  pcnt;
  logic [CRC_W-1:0]  run_crc, held_crc;
  logic [SYNC_W-2:0] cmp_sh;

  logic              before_sync, at_sync, begin_pkt, drop, in_sync, pkt_done;
  logic              chk_ev, crc_bad;
  logic [LEN_W-1:0]  pos;
  logic [SEL_W-1:0]  sel;
  logic [CRC_W-1:0]  crc_next;
  logic [SYNC_W-1:0] sync_rx;

  always_comb begin
    before_sync = d_idx < syncd;
    at_sync     = d_idx == syncd;
    begin_pkt   = at_sync || (!before_sync && !active);
    drop        = before_sync && !active;
    pos         = begin_pkt ? '0 : pcnt;
    in_sync     = pos < LEN_W'(SYNC_W);
    pkt_done    = pos == upl - 1'b1;
    sel         = SEL_W'(SYNC_W - 1) - pos[SEL_W-1:0];
    crc_next    = crc_step((pos == LEN_W'(SYNC_W)) ? '0 : run_crc, d_bit);
    sync_rx     = {cmp_sh, d_bit};
    chk_ev      = d_vld && !cont_mode && !drop && have_prev
                  && (pos == LEN_W'(SYNC_W - 1));
    crc_bad     = chk_ev && (sync_rx != held_crc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; have_prev <= 1'b0; pcnt <= '0;
      run_crc <= '0; held_crc <= '0; cmp_sh <= '0;
      o_bit <= 1'b0; o_vld <= 1'b0; o_start <= 1'b0;
      o_end <= 1'b0; o_err <= 1'b0; o_inv <= 1'b0;
    end else begin
      o_bit <= 1'b0; o_vld <= 1'b0; o_start <= 1'b0;
      o_end <= 1'b0; o_err <= 1'b0; o_inv <= 1'b0;
      if (flush) begin
        active    <= 1'b0;
        have_prev <= 1'b0;
      end else if (d_vld) begin
        if (cont_mode) begin
          o_vld   <= 1'b1;
          o_bit   <= d_bit;
          o_start <= d_first;
          o_end   <= d_last;
        end else if (drop) begin
          o_inv <= 1'b1;
        end else begin
          o_vld   <= 1'b1;
          o_bit   <= in_sync ? sync_word[sel] : d_bit;
          o_start <= (pos == '0);
          o_end   <= pkt_done;
          o_err   <= crc_bad;
          if (in_sync) cmp_sh  <= sync_rx[SYNC_W-2:0];
          else         run_crc <= crc_next;
          if (pos == LEN_W'(SYNC_W - 1)) have_prev <= 1'b0;
          if (pkt_done) begin
            active    <= 1'b0;
            held_crc  <= crc_next;
            have_prev <= 1'b1;
          end else begin
            active <= 1'b1;
          end
          pcnt <= pos + 1'b1;
        end
      end
    end
  end

  // continuous mode never raises packet flags (R5)
  p_cont_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && cont_mode) |=> (!o_err && !o_inv));
  // a packet error comes with a mid-sync-byte output bit (R8)
  p_err_on_sync_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_err |-> (o_vld && !o_start && !o_end));
  // a dropped bit is never also delivered (R9)
  p_drop_not_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && !cont_mode && drop) |=> (o_inv && !o_vld));
endmodule

// File: rtl/bbr_stream_recover.sv
module bbr_stream_recover
  import bbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_bit,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_end,
  output logic              out_bit,
  output logic              out_valid,
  output logic              out_start,
  output logic              out_end,
  output logic              pkt_err,
  output logic              pkt_invalid,
  output logic [1:0]        hdr_crc_status,
  output logic [1:0]        f_stream_fmt,
  output logic              f_multi_stream,
  output logic              f_acm,
  output logic              f_issy,
  output logic              f_npd,
  output logic [1:0]        f_roll_off,
  output logic [7:0]        f_stream_id,
  output logic [LEN_W-1:0]  f_upl,
  output logic [LEN_W-1:0]  f_dfl,
  output logic [SYNC_W-1:0] f_sync,
  output logic [LEN_W-1:0]  f_syncd
);
  hdr_t             hf;
  logic             hdr_ok, hdr_fail;
  logic             d_vld, d_bit, d_first, d_last;
  logic [LEN_W-1:0] d_idx;
  logic             cont_mode;
  logic             frame_ok_q;

  bbr_hdr_parse i_parse (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .in_start(in_start), .in_end(in_end), .fields(hf),
    .hdr_ok(hdr_ok), .hdr_fail(hdr_fail), .d_vld(d_vld), .d_bit(d_bit),
    .d_first(d_first), .d_last(d_last), .d_idx(d_idx)
  );

  assign cont_mode = (hf.fmt == FMT_CONT);

  bbr_pkt_frame i_frame (
    .clk(clk), .rst_n(rst_n), .d_vld(d_vld), .d_bit(d_bit),
    .d_first(d_first), .d_last(d_last), .d_idx(d_idx), .upl(hf.upl),
    .syncd(hf.syncd), .sync_word(hf.sync), .cont_mode(cont_mode),
    .flush(hdr_fail), .o_bit(out_bit), .o_vld(out_valid),
    .o_start(out_start), .o_end(out_end), .o_err(pkt_err),
    .o_inv(pkt_invalid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_crc_status <= 2'b00;
      frame_ok_q     <= 1'b0;
    end else begin
      hdr_crc_status <= {hdr_fail, hdr_ok || hdr_fail};
      if (hdr_ok)   frame_ok_q <= 1'b1;
      if (hdr_fail) frame_ok_q <= 1'b0;
    end
  end

  assign f_stream_fmt   = hf.fmt;
  assign f_multi_stream = hf.multi;
  assign f_acm          = hf.acm;
  assign f_issy         = hf.issy;
  assign f_npd          = hf.npd;
  assign f_roll_off     = hf.roll;
  assign f_stream_id    = hf.sid;
  assign f_upl          = hf.upl;
  assign f_dfl          = hf.dfl;
  assign f_sync         = hf.sync;
  assign f_syncd        = hf.syncd;

  // status is a single-cycle report (R2)
  p_status_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_crc_status[0] |=> !hdr_crc_status[0]);
  // no valid output after a failed header until a good one (R3)
  p_no_data_after_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> frame_ok_q);
endmodule

// File: tb/test_bbr_stream_recover.sv
module test_bbr_stream_recover;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_bit = 1'b0, in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
  logic out_bit, out_valid, out_start, out_end, pkt_err, pkt_invalid;
  logic [1:0] hdr_crc_status, f_stream_fmt, f_roll_off;
  logic f_multi_stream, f_acm, f_issy, f_npd;
  logic [7:0] f_stream_id, f_sync;
  logic [15:0] f_upl, f_dfl, f_syncd;

  always #4 clk = ~clk;

  bbr_stream_recover i_bbr_stream_recover (.*);

  typedef struct packed { logic b; logic st; logic en; logic er; logic inv; } exp_t;
  exp_t  eq[$];
  string tq[$];
  bit    dq[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  localparam logic [7:0] SYNC = 8'h47;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_bits(input logic [79:0] v, input int n);
    logic [7:0] r = 8'h00;
    for (int i = n - 1; i >= 0; i--) begin
      logic t;
      t = r[7] ^ v[i];
      r = r << 1;
      if (t) r = r ^ 8'hD5;
    end
    return r;
  endfunction

  function automatic logic [7:0] pcrc(input logic [23:0] pl);
    return crc_bits({56'h0, pl}, 24);
  endfunction

  function automatic logic [79:0] mk_hdr(input logic [1:0] fmt, input logic [7:0] sid,
      input logic [15:0] upl, input logic [15:0] dfl, input logic [15:0] syncd, input bit bad);
    logic [71:0] h;
    h = {fmt, 1'b1, 1'b0, 1'b1, 1'b0, 2'b10, sid, upl, dfl, SYNC, syncd};
    return {h, crc_bits({8'h0, h}, 72) ^ (bad ? 8'h5A : 8'h00)};
  endfunction

  // packet of 32 bits: slot byte then 24 payload bits; bits from..to are sent
  task automatic add_pkt(input logic [23:0] pl, input logic [7:0] slot, input int from,
      input int to, input bit experr, input string tag);
    for (int p = from; p <= to; p++) begin
      exp_t e;
      dq.push_back(p < 8 ? slot[7-p] : pl[31-p]);
      e.b = p < 8 ? SYNC[7-p] : pl[31-p];
      e.st = (p == 0); e.en = (p == 31); e.er = experr && (p == 7); e.inv = 1'b0;
      eq.push_back(e); tq.push_back(tag);
    end
  endtask

  task automatic add_junk(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      dq.push_back(i[0]);
      e = '0; e.inv = 1'b1;
      eq.push_back(e); tq.push_back("R9 dropped bit");
    end
  endtask

  task automatic add_raw(input int n);
    for (int i = 0; i < n; i++) dq.push_back(i[1]);
  endtask

  task automatic add_cont(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      dq.push_back(i[0] ^ i[2]);
      e.b = i[0] ^ i[2]; e.st = (i == 0); e.en = (i == n - 1); e.er = 0; e.inv = 0;
      eq.push_back(e); tq.push_back("R5 continuous");
    end
  endtask

  task automatic send_frame(input logic [79:0] h, input int pad, input bit gaps,
      input logic [1:0] exp_st);
    int n;
    n = 80 + dq.size() + pad;
    for (int k = 0; k < n; k++) begin
      if (gaps && k >= 84 && (k % 3 == 0)) begin
        @(posedge clk); #1;
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0; in_bit = ~in_bit;
      end
      @(posedge clk); #1;
      if (k == 80) chk(hdr_crc_status == exp_st, "R2 header status", hdr_crc_status, exp_st);
      if (k == 82) chk(hdr_crc_status == 2'b00, "R2 status idle", hdr_crc_status, 0);
      in_valid = 1'b1;
      in_start = (k == 0);
      in_end   = (k == n - 1);
      if (k < 80) in_bit = h[79-k];
      else if (k < 80 + dq.size()) in_bit = dq[k-80];
      else in_bit = k[0];
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    chk(eq.size() == 0, "R4 all expected bits seen, none extra", eq.size(), 0);
    dq.delete();
  endtask

  // monitor: compare every output event with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pkt_err && !out_valid) chk(0, "R8 pkt_err without valid", 1, 0);
      if (out_valid || pkt_invalid) begin
        if (eq.size() == 0) begin
          chk(0, "R4/R11 unexpected output", {out_valid, pkt_invalid}, 0);
        end else begin
          exp_t e, a;
          string t;
          e = eq.pop_front(); t = tq.pop_front();
          a = {out_bit, out_start, out_end, pkt_err, pkt_invalid};
          if (e.inv) chk(pkt_invalid && !out_valid, t, {out_valid, pkt_invalid}, 1);
          else chk(out_valid && a == e, t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] p0, p1, p2, p3, p4, p5, p6;
    p0 = 24'hA1B2C3; p1 = 24'h0F1E2D; p2 = 24'h5A5A33; p3 = 24'hC0FFEE;
    p4 = 24'h123456; p5 = 24'h789ABC; p6 = 24'h2468AC;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && pkt_invalid == 0 && pkt_err == 0, "R12 reset outputs", out_valid, 0);
    chk(hdr_crc_status == 0 && f_dfl == 0 && f_upl == 0, "R12 reset fields", f_dfl, 0);

    // frame A: packetized, boundary at 0, error on third packet, one packet left open
    add_pkt(p0, 8'h00, 0, 31, 0, "R6/R7 first packet");
    add_pkt(p1, pcrc(p0), 0, 31, 0, "R8 good crc packet");
    add_pkt(p2, pcrc(p1) ^ 8'h10, 0, 31, 1, "R8 crc mismatch");
    add_pkt(p3, pcrc(p2), 0, 15, 0, "R6 open packet head");
    send_frame(mk_hdr(2'b11, 8'h05, 16'd32, 16'd112, 16'd0, 0), 0, 0, 2'b01);
    chk(f_stream_fmt == 2'b11 && f_multi_stream && !f_acm, "R1 format/flags", f_stream_fmt, 3);
    chk(f_issy && !f_npd && f_roll_off == 2'b10, "R1 issy/npd/roll", f_roll_off, 2);
    chk(f_stream_id == 8'h05 && f_sync == SYNC, "R1 stream id/sync", f_stream_id, 5);
    chk(f_upl == 32 && f_dfl == 112 && f_syncd == 0, "R1 lengths", f_dfl, 112);

    // frame B: carried packet tail before SYNCD, then new packets, plus padding
    add_pkt(p3, 8'h00, 16, 31, 0, "R10 carried packet tail");
    add_pkt(p4, pcrc(p3), 0, 31, 0, "R6 packet at SYNCD");
    add_pkt(p5, pcrc(p4), 0, 15, 0, "R8 good crc after carry");
    send_frame(mk_hdr(2'b00, 8'h3C, 16'd32, 16'd64, 16'd16, 0), 8, 0, 2'b01);
    chk(f_syncd == 16 && f_dfl == 64 && f_stream_id == 8'h3C, "R1 second header", f_syncd, 16);

    // frame C: corrupted header CRC, nothing may come out
    add_raw(40);
    send_frame(mk_hdr(2'b00, 8'h77, 16'd32, 16'd40, 16'd0, 1), 0, 0, 2'b11);
    chk(f_syncd == 16 && f_dfl == 64 && f_stream_id == 8'h3C, "R1 fields hold on fail", f_dfl, 64);

    // frame D: pending state was discarded, so bits before SYNCD are dropped
    add_junk(16);
    add_pkt(p6, 8'hFF, 0, 31, 0, "R3 no check after dropped frame");
    send_frame(mk_hdr(2'b00, 8'h11, 16'd32, 16'd48, 16'd16, 0), 0, 0, 2'b01);

    // frame E: continuous stream with idle cycles and padding
    add_cont(20);
    send_frame(mk_hdr(2'b01, 8'h22, 16'd0, 16'd20, 16'd0, 0), 4, 1, 2'b01);
    chk(f_stream_fmt == 2'b01 && f_dfl == 20, "R5 continuous header", f_stream_fmt, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule